// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear Commands

This block watches for a stalled program. A selectable slow tick source drives a prescaler and a main counter. When the two run out together the block expires. While the system runs, an expiry asks for a reset. While the system is halted, an expiry instead wakes it, so a halted system can be woken at regular intervals. The block also keeps a time-out flag and a power-down flag, which firmware reads after a reset or a wake-up to learn why it is running.

Firmware keeps the timer from expiring by issuing two different clear strobes, one after the other. A single strobe, or the same strobe repeated, leaves the timer running. This guards against a runaway loop that happens to hit one clear command. A halt strobe puts the system into the halted state. After a wake-up, an execution hold output stays high for a set number of system clocks so that the clock can settle.

Top module: `wdt_dualclr_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), to_flag, pd_flag, halted, hold_exec, rst_req and wake_pulse are all 0.
- R2: With wdt_en high and the selected tick high every cycle, an expiry happens on the 2^(PRE_W+CNT_W)-th counted tick. While not halted, rst_req is high for exactly one cycle, starting the cycle after the edge of that tick, and to_flag becomes 1 in the same cycle.
- R3: Only tick_src[tick_sel] advances the prescaler. Ticks on the other sources have no effect.
- R4: clr_a followed later by clr_b, or clr_b followed later by clr_a, completes a clear pair. A completed pair zeroes the prescaler and the counter and clears to_flag and pd_flag.
- R5: Repeating the same clear strobe without the other one in between completes no pair. A cycle with clr_a and clr_b both high is ignored and leaves the sequence state unchanged.
- R6: After a completed pair the sequence state is empty, so the next clear needs a fresh pair. halt_cmd does not change the sequence state.
- R7: halt_cmd zeroes the prescaler and the counter, sets pd_flag, clears to_flag and sets halted, all visible in the next cycle.
- R8: An expiry while halted raises wake_pulse for one cycle instead of rst_req. It clears halted and sets to_flag.
- R9: hold_exec is high for exactly WAKE_CYCLES cycles, starting in the cycle in which wake_pulse is high.
- R10: While wdt_en is low, the prescaler and the counter hold their values and no expiry occurs. Counting resumes from the held value when wdt_en returns high.
- R11: In the same cycle, halt_cmd takes priority over a completed pair, and a completed pair takes priority over an expiry. An expiry that is overridden produces no rst_req and no wake_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| wdt_en | input | 1 | Configuration enable. Low holds the timer |
| tick_src | input | NUM_SRC | Slow tick enables, one per source |
| tick_sel | input | SEL_W | Selects the tick source |
| clr_a | input | 1 | First clear command strobe |
| clr_b | input | 1 | Second clear command strobe |
| halt_cmd | input | 1 | Halt-entry strobe |
| rst_req | output | 1 | One-cycle reset request on expiry while running |
| wake_pulse | output | 1 | One-cycle wake-up on expiry while halted |
| to_flag | output | 1 | Time-out flag |
| pd_flag | output | 1 | Power-down flag |
| halted | output | 1 | System is in the halted state |
| hold_exec | output | 1 | Execution hold after a wake-up |

## Verification
The bench builds the block with PRE_W=2, CNT_W=3 and WAKE_CYCLES=8. A full expiry then takes 32 counted ticks and a wake hold lasts 8 cycles. These short windows make it practical to check the exact expiry cycle, a pause in mid-count with the enable low, the alternate tick source, and a clear or halt that lands on the same cycle as an expiry. With both commands, repeats and simultaneous strobes driven while the timer is frozen, the clear-sequence rules can be read directly from the two flags.

// File: rtl/wdt_dc_pkg.sv
// Shared types for the paired-clear watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdt_dc_pkg;
    // Progress of the clear-command pair
    typedef enum logic [1:0] {
        SEQ_EMPTY = 2'd0,
        SEQ_GOT_A = 2'd1,
        SEQ_GOT_B = 2'd2
    } seq_state_t;
endpackage

// File: rtl/wdt_timebase.sv
// Tick selection, prescaler and main counter of the watchdog.
// Produces a combinational expire strobe in the cycle whose tick
// wraps both stages. A clear zeroes both stages and has priority.
// Assumes: tick_src entries are one-cycle enables in the clk domain.
module wdt_timebase #(
    parameter int NUM_SRC = 2,
    parameter int PRE_W   = 7,
    parameter int CNT_W   = 8,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic [SEL_W-1:0]   tick_sel,
    input  logic               clear,
    output logic               expire
);
    logic             step;
    logic             pre_carry;
    logic [CNT_W-1:0] cnt_q;

    // Pick the selected source and gate it with the enable
    always_comb begin
        step = en & tick_src[tick_sel];
    end

    generate
        if (PRE_W > 0) begin : g_pre
            logic [PRE_W-1:0] pre_q;

            // Prescaler count, cleared on request
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    pre_q <= '0;
                end else if (step) begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign pre_carry = step & (&pre_q);

            AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!en && !clear) |=> $stable(pre_q)); // R10
        end else begin : g_nopre
            assign pre_carry = step;
        end
    endgenerate

    // Main counter advanced by prescaler carries
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (pre_carry) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = pre_carry & (&cnt_q);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> $stable(cnt_q)); // R10
    AST_NO_EXPIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !expire); // R10
endmodule

// File: rtl/wdt_clear_seq.sv
// Tracks the two clear strobes. A pair completes when the second,
// different strobe follows the first. Repeats keep the state, and a
// cycle with both strobes high is ignored. The state empties after
// each completed pair.
// Assumes: strobes are single-cycle requests from the instruction side.
module wdt_clear_seq
    import wdt_dc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_a,
    input  logic clr_b,
    output logic pair_done
);
    seq_state_t st_q;
    seq_state_t st_d;
    logic       only_a;
    logic       only_b;

    // Decode the strobes and form the next state
    always_comb begin
        only_a    = clr_a & ~clr_b;
        only_b    = clr_b & ~clr_a;
        pair_done = (st_q == SEQ_GOT_A && only_b) || (st_q == SEQ_GOT_B && only_a);
        st_d      = st_q;
        if (pair_done) begin
            st_d = SEQ_EMPTY;
        end else if (only_a) begin
            st_d = SEQ_GOT_A;
        end else if (only_b) begin
            st_d = SEQ_GOT_B;
        end
    end

    // State register for the pair tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PAIR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |=> (st_q == SEQ_EMPTY)); // R6
    AST_REPEAT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_GOT_A && clr_a) |-> !pair_done); // R5
    AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && clr_b) |=> $stable(st_q)); // R5
endmodule

// File: rtl/wdt_wake_hold.sv
// Holds off execution for a fixed number of cycles after a wake-up.
// hold is high in the cycle after start and for WAKE_CYCLES cycles in all.
// Assumes: WAKE_CYCLES >= 1.
module wdt_wake_hold #(
    parameter int WAKE_CYCLES = 1024,
    localparam int HW = $clog2(WAKE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic hold
);
    logic [HW-1:0] left_q;

    // Load on start, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= HW'(WAKE_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign hold = (left_q != '0);

    AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> hold); // R9
endmodule

// File: rtl/wdt_dualclr_top.sv
// Watchdog top: combines the timebase, the clear-pair tracker and the
// wake hold, and keeps the time-out, power-down and halted state.
// Priority in one cycle: halt, then a completed pair, then an expiry.
// Assumes: commands are single-cycle strobes synchronous to clk.
module wdt_dualclr_top #(
    parameter int NUM_SRC     = 2,
    parameter int PRE_W       = 7,
    parameter int CNT_W       = 8,
    parameter int WAKE_CYCLES = 1024,
    localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wdt_en,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic [SEL_W-1:0]   tick_sel,
    input  logic               clr_a,
    input  logic               clr_b,
    input  logic               halt_cmd,
    output logic               rst_req,
    output logic               wake_pulse,
    output logic               to_flag,
    output logic               pd_flag,
    output logic               halted,
    output logic               hold_exec
);
    logic pair_done;
    logic expire;
    logic tb_clear;
    logic expire_eff;
    logic wake_start;

    // Clear the timebase on a halt or a completed pair; mask an overridden expiry
    always_comb begin
        tb_clear   = halt_cmd | pair_done;
        expire_eff = expire & ~tb_clear;
        wake_start = expire_eff & halted;
    end

    wdt_timebase #(
        .NUM_SRC (NUM_SRC),
        .PRE_W   (PRE_W),
        .CNT_W   (CNT_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (wdt_en),
        .tick_src (tick_src),
        .tick_sel (tick_sel),
        .clear    (tb_clear),
        .expire   (expire)
    );

    wdt_clear_seq u_clear_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .pair_done (pair_done)
    );

    wdt_wake_hold #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_wake_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wake_start),
        .hold  (hold_exec)
    );

    // Flags, halted state and the one-cycle outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag    <= 1'b0;
            pd_flag    <= 1'b0;
            halted     <= 1'b0;
            rst_req    <= 1'b0;
            wake_pulse <= 1'b0;
        end else begin
            rst_req    <= expire_eff & ~halted;
            wake_pulse <= wake_start;
            if (halt_cmd) begin
                pd_flag <= 1'b1;
                to_flag <= 1'b0;
                halted  <= 1'b1;
            end else if (pair_done) begin
                pd_flag <= 1'b0;
                to_flag <= 1'b0;
            end else if (expire_eff) begin
                to_flag <= 1'b1;
                halted  <= 1'b0;
            end
        end
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R2
    AST_RST_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> to_flag); // R2
    AST_NO_RST_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !rst_req); // R8
    AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (!halted && to_flag)); // R8
    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> hold_exec); // R9
    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cmd |=> (pd_flag && !to_flag && halted)); // R7
    AST_HALT_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cmd |=> (!rst_req && !wake_pulse)); // R11
    AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_done && !halt_cmd) |=> (!to_flag && !pd_flag && !rst_req)); // R4
endmodule

// File: tb/wdt_dualclr_top_tb.sv
// Self-checking bench for wdt_dualclr_top.
module wdt_dualclr_top_tb;
    localparam int NUM_SRC = 2;
    localparam int PRE_W   = 2;
    localparam int CNT_W   = 3;
    localparam int WAKE    = 8;
    localparam int PERIOD  = 1 << (PRE_W + CNT_W);

    // Vector: {op[2:0], exp_to, exp_pd}; op 0 none, 1 clr_a, 2 clr_b, 3 both, 4 halt
    localparam int NVEC = 11;
    localparam logic [4:0] VEC [NVEC] = '{
        5'b001_1_0, 5'b001_1_0, 5'b010_0_0, 5'b100_0_1, 5'b010_0_1, 5'b010_0_1,
        5'b011_0_1, 5'b001_0_0, 5'b100_0_1, 5'b010_0_1, 5'b001_0_0
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               wdt_en;
    logic [NUM_SRC-1:0] tick_src;
    logic               tick_sel;
    logic               clr_a, clr_b, halt_cmd;
    logic               rst_req, wake_pulse, to_flag, pd_flag, halted, hold_exec;

    int n_chk  = 0;
    int n_fail = 0;
    int n_cyc  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdt_dualclr_top #(
        .NUM_SRC (NUM_SRC), .PRE_W (PRE_W), .CNT_W (CNT_W), .WAKE_CYCLES (WAKE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .wdt_en (wdt_en), .tick_src (tick_src),
        .tick_sel (tick_sel), .clr_a (clr_a), .clr_b (clr_b), .halt_cmd (halt_cmd),
        .rst_req (rst_req), .wake_pulse (wake_pulse), .to_flag (to_flag),
        .pd_flag (pd_flag), .halted (halted), .hold_exec (hold_exec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic pair();
        clr_a = 1'b1; cyc(); clr_a = 1'b0;
        clr_b = 1'b1; cyc(); clr_b = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; wdt_en = 1'b1; tick_src = '0; tick_sel = 1'b0;
        clr_a = 1'b0; clr_b = 1'b0; halt_cmd = 1'b0;
        @(negedge clk);
        repeat (3) cyc();
        // R1 reset state
        chk("R1 to", to_flag, 0); chk("R1 pd", pd_flag, 0); chk("R1 halted", halted, 0);
        chk("R1 hold", hold_exec, 0); chk("R1 rst", rst_req, 0); chk("R1 wake", wake_pulse, 0);
        rst_n = 1'b1;

        // R2 expiry timing in the run state
        tick_src[0] = 1'b1;
        for (int i = 0; i < PERIOD - 1; i++) begin cyc(); chk("R2 early", rst_req, 0); end
        cyc();
        chk("R2 rst", rst_req, 1); chk("R2 to", to_flag, 1);
        tick_src[0] = 1'b0;
        cyc();
        chk("R2 one cycle", rst_req, 0);

        // R4 R5 R6 R7 table walk with the timer frozen
        for (int v = 0; v < NVEC; v++) begin
            clr_a    = (VEC[v][4:2] == 3'd1) || (VEC[v][4:2] == 3'd3);
            clr_b    = (VEC[v][4:2] == 3'd2) || (VEC[v][4:2] == 3'd3);
            halt_cmd = (VEC[v][4:2] == 3'd4);
            cyc();
            clr_a = 1'b0; clr_b = 1'b0; halt_cmd = 1'b0;
            chk($sformatf("R4/R5/R6 row %0d to", v), to_flag, VEC[v][1]);
            chk($sformatf("R4/R5/R6 row %0d pd", v), pd_flag, VEC[v][0]);
        end
        chk("R7 halted", halted, 1);

        // R8 R9 expiry while halted wakes
        tick_src[0] = 1'b1;
        for (int i = 0; i < PERIOD - 1; i++) begin cyc(); chk("R8 early", wake_pulse, 0); end
        cyc();
        tick_src[0] = 1'b0;
        chk("R8 wake", wake_pulse, 1); chk("R8 no rst", rst_req, 0);
        chk("R8 halted", halted, 0); chk("R8 to", to_flag, 1); chk("R9 hold", hold_exec, 1);
        for (int i = 1; i < WAKE; i++) begin cyc(); chk("R9 held", hold_exec, 1); end
        cyc();
        chk("R9 released", hold_exec, 0);

        // R10 disable holds the count
        pair();
        chk("R4 pair", to_flag, 0);
        tick_src[0] = 1'b1;
        repeat (10) cyc();
        wdt_en = 1'b0;
        for (int i = 0; i < 50; i++) begin cyc(); chk("R10 off", rst_req, 0); end
        wdt_en = 1'b1;
        for (int i = 0; i < PERIOD - 11; i++) begin cyc(); chk("R10 resume", rst_req, 0); end
        cyc();
        chk("R10 expiry after resume", rst_req, 1);
        tick_src[0] = 1'b0;

        // R3 alternate tick source
        pair();
        tick_sel = 1'b1; tick_src[0] = 1'b1;
        for (int i = 0; i < PERIOD - 1; i++) begin
            tick_src[1] = 1'b1; cyc(); chk("R3 src1 hi", rst_req, 0);
            tick_src[1] = 1'b0; cyc(); chk("R3 src1 lo", rst_req, 0);
        end
        tick_src[1] = 1'b1; cyc();
        chk("R3 expiry", rst_req, 1);
        tick_src = '0; tick_sel = 1'b0;
        cyc();

        // R11 pair beats expiry, then halt beats expiry
        pair();
        tick_src[0] = 1'b1;
        clr_a = 1'b1; cyc(); clr_a = 1'b0;
        repeat (PERIOD - 2) cyc();
        clr_b = 1'b1; cyc(); clr_b = 1'b0;
        chk("R11 pair over expiry rst", rst_req, 0); chk("R11 pair over expiry to", to_flag, 0);
        for (int i = 0; i < PERIOD - 1; i++) begin cyc(); chk("R11 restart", rst_req, 0); end
        cyc();
        chk("R11 restarted expiry", rst_req, 1);
        repeat (PERIOD - 1) cyc();
        halt_cmd = 1'b1; cyc(); halt_cmd = 1'b0;
        tick_src[0] = 1'b0;
        chk("R11 halt over expiry rst", rst_req, 0); chk("R11 halt over expiry wake", wake_pulse, 0);
        chk("R7 pd", pd_flag, 1); chk("R7 to", to_flag, 0); chk("R7 halted", halted, 1);
        cyc();
        chk("R11 quiet", rst_req | wake_pulse, 0);

        done = 1'b1;
        summary();
    end
endmodule